// File: doc/BRIEF.md
# AC-link Codec Reset Sequencer

This block produces the two kinds of reset that an AC'97-style audio codec accepts over its AC-link. A cold reset first gives the local link controller a one-cycle enable drop to clear its own state. It then holds the active-low codec reset line low for a host-chosen number of system-clock cycles and releases it. A warm reset raises the sync line for a host-chosen number of cycles. The block allows this only when the codec's bit clock has stopped, because a warm reset leaves the codec's registers unchanged and is only meaningful on a silent link.

After either pulse the block waits for the codec to bring its bit clock back. The bit clock is brought into the system domain through a two-flop synchronizer. A transition seen there marks the link as running, sets a start-of-frame flag and, if the host has enabled it, raises an interrupt. An idle-cycle counter declares the bit clock absent after a fixed number of system cycles without a transition. A warm request made while the clock is still present is refused and sets an error flag. A busy flag covers the whole sequence, and requests made while it is set have no effect.

Top module: `aclink_rst_seq`

## Requirements
- R1: After reset: codec_rst_n=1, sync_o=0, ctl_en=1, busy=0, sof_flag=0, err_flag=0, irq=0.
- R2: An accepted cold request drops ctl_en for exactly one cycle. In the cycle after that, codec_rst_n goes low and stays low for exactly cold_cycles cycles. A cold_cycles value of 0 is treated as 1.
- R3: An accepted warm request drives sync_o high for exactly warm_cycles cycles. A warm_cycles value of 0 selects WARM_DEF_CYCLES = CLK_MHZ cycles (1 us). The request is accepted only while the bit clock is judged absent.
- R4: When cold_req and warm_req arrive in the same idle cycle, the cold reset runs and no sync pulse is produced.
- R5: A warm request while the bit clock is judged present sets err_flag. busy stays 0 and sync_o stays 0.
- R6: busy rises in the cycle after an accepted request. It stays high until a bit-clock transition is detected after the reset pulse has ended. Cold or warm requests made while busy produce no ctl_en drop, no codec_rst_n low and no sync pulse.
- R7: The bit clock is judged present from the cycle after a synchronized transition is detected. It is judged absent once ABSENT_CYCLES system cycles pass without a transition.
- R8: sof_flag is set when the wait for the bit clock ends. irq equals sof_flag AND irq_en.
- R9: A pulse on clr_flags clears sof_flag and err_flag. When a flag is set in the same cycle as clr_flags, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cold_req | input | 1 | Cold reset start bit (sampled while idle) |
| warm_req | input | 1 | Warm reset start bit (sampled while idle) |
| cold_cycles | input | CNT_W | Codec reset low time in system cycles |
| warm_cycles | input | CNT_W | Sync high time in system cycles, 0 selects default |
| irq_en | input | 1 | Interrupt mask bit for start-of-frame |
| clr_flags | input | 1 | Clears sof_flag and err_flag |
| bitclk | input | 1 | Codec-supplied bit clock (asynchronous) |
| codec_rst_n | output | 1 | Active-low codec reset line |
| sync_o | output | 1 | AC-link sync line |
| ctl_en | output | 1 | Link controller enable, low for one cycle before a cold reset |
| busy | output | 1 | Reset sequence in progress |
| sof_flag | output | 1 | Link resumed (start-of-frame) status |
| err_flag | output | 1 | Warm request refused status |
| irq | output | 1 | Start-of-frame interrupt |

## Verification
The hardest case to reach is a warm reset that is accepted. The bit clock has to be stopped, and the stimulus must then wait out both the synchronizer delay and the full absence window. A request made just before the window expires has to be refused, and one made just after it has to be accepted. The bench plays the codec: it starts and stops the bit clock at chosen points and checks that a warm request made shortly after the clock stops still sets the error flag. The bench also holds clr_flags high across the moment the link resumes, which makes the set-versus-clear collision happen.

// File: rtl/aclink_rst_pkg.sv
// Package: shared types for the AC-link reset sequencer.
package aclink_rst_pkg;
    // Sequencer states; order has no behavioural meaning.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CTL_CLR   = 3'd1,
        ST_COLD_LOW  = 3'd2,
        ST_WARM_HIGH = 3'd3,
        ST_WAIT_BCLK = 3'd4
    } seq_state_t;
endpackage

// File: rtl/aclink_bclk_mon.sv
// Bit-clock monitor. Brings the codec bit clock into the system domain
// through two flops and then flags transitions. It also keeps a
// presence bit that is cleared after ABSENT_CYCLES cycles without a
// transition. Assumes the bit clock is slower than half the system clock.
module aclink_bclk_mon #(
    parameter int ABSENT_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bitclk,
    output logic bclk_edge,
    output logic clk_present
);
    localparam int IW = $clog2(ABSENT_CYCLES + 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(ABSENT_CYCLES - 1);

    logic [2:0]    sync_q;
    logic [IW-1:0] idle_cnt;

    // Synchronizer (two flops) plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], bitclk};
    end

    assign bclk_edge = sync_q[1] ^ sync_q[2];

    // Presence tracking: set on a transition, cleared after the idle window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt    <= '0;
            clk_present <= 1'b0;
        end else if (bclk_edge) begin
            idle_cnt    <= '0;
            clk_present <= 1'b1;
        end else if (idle_cnt < IDLE_LAST) begin
            idle_cnt    <= idle_cnt + 1'b1;
        end else begin
            clk_present <= 1'b0;
        end
    end

    AST_PRESENT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_edge |=> clk_present); // R7
endmodule

// File: rtl/aclink_dur_cnt.sv
// Duration counter. Counts cycles while run is high and raises last in
// the final cycle of a target-length window. Assumes target >= 1.
// The count returns to zero whenever run is low.
module aclink_dur_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] target,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    assign last = run && (cnt == target - 1'b1);

    // Count elapsed cycles of the current timed phase.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (run && !last) cnt <= cnt + 1'b1;
        else                   cnt <= '0;
    end

    AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (cnt == '0)); // R2
endmodule

// File: rtl/aclink_rst_fsm.sv
// Reset sequencer control. Accepts cold and warm requests while idle.
// It orders the controller clear, the codec reset pulse or sync pulse,
// and then the wait for the bit clock. It also holds the status flags.
// Assumes cold_cycles and warm_cycles stay steady during a sequence.
module aclink_rst_fsm
    import aclink_rst_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CLK_MHZ = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cold_req,
    input  logic             warm_req,
    input  logic [CNT_W-1:0] cold_cycles,
    input  logic [CNT_W-1:0] warm_cycles,
    input  logic             irq_en,
    input  logic             clr_flags,
    input  logic             clk_present,
    input  logic             bclk_edge,
    input  logic             dur_last,
    output logic             dur_run,
    output logic [CNT_W-1:0] dur_target,
    output logic             codec_rst_n,
    output logic             sync_o,
    output logic             ctl_en,
    output logic             busy,
    output logic             sof_flag,
    output logic             err_flag,
    output logic             irq
);
    localparam logic [CNT_W-1:0] WARM_DEF = CNT_W'(CLK_MHZ);

    seq_state_t       state, state_nx;
    logic [CNT_W-1:0] cold_eff, warm_eff;
    logic             sof_set, err_set;

    assign cold_eff = (cold_cycles == '0) ? CNT_W'(1) : cold_cycles;
    assign warm_eff = (warm_cycles == '0) ? WARM_DEF : warm_cycles;

    // Next-state selection; cold takes priority over warm.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cold_req)                      state_nx = ST_CTL_CLR;
                else if (warm_req && !clk_present) state_nx = ST_WARM_HIGH;
            end
            ST_CTL_CLR:   state_nx = ST_COLD_LOW;
            ST_COLD_LOW:  if (dur_last)  state_nx = ST_WAIT_BCLK;
            ST_WARM_HIGH: if (dur_last)  state_nx = ST_WAIT_BCLK;
            ST_WAIT_BCLK: if (bclk_edge) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign dur_run    = (state == ST_COLD_LOW) || (state == ST_WARM_HIGH);
    assign dur_target = (state == ST_WARM_HIGH) ? warm_eff : cold_eff;

    assign sof_set = (state == ST_WAIT_BCLK) && bclk_edge;
    assign err_set = (state == ST_IDLE) && !cold_req && warm_req && clk_present;

    // Status flags: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            if (sof_set)        sof_flag <= 1'b1;
            else if (clr_flags) sof_flag <= 1'b0;
            if (err_set)        err_flag <= 1'b1;
            else if (clr_flags) err_flag <= 1'b0;
        end
    end

    assign codec_rst_n = (state != ST_COLD_LOW);
    assign sync_o      = (state == ST_WARM_HIGH);
    assign ctl_en      = (state != ST_CTL_CLR);
    assign busy        = (state != ST_IDLE);
    assign irq         = sof_flag && irq_en;

    AST_CTL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (ctl_en && !codec_rst_n)); // R2
    AST_WARM_NEEDS_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(!clk_present)); // R3
    AST_ERR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> !busy); // R5
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bclk_edge) |=> busy); // R6
    AST_SOF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> sof_flag); // R8
endmodule

// File: rtl/aclink_rst_seq.sv
// AC-link codec reset sequencer top. Connects the bit-clock monitor,
// the duration counter and the control FSM. The bitclk input is
// asynchronous; all other inputs are synchronous to clk.
module aclink_rst_seq #(
    parameter int CNT_W         = 16,
    parameter int CLK_MHZ       = 100,
    parameter int ABSENT_CYCLES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cold_req,
    input  logic             warm_req,
    input  logic [CNT_W-1:0] cold_cycles,
    input  logic [CNT_W-1:0] warm_cycles,
    input  logic             irq_en,
    input  logic             clr_flags,
    input  logic             bitclk,
    output logic             codec_rst_n,
    output logic             sync_o,
    output logic             ctl_en,
    output logic             busy,
    output logic             sof_flag,
    output logic             err_flag,
    output logic             irq
);
    logic             bclk_edge, clk_present;
    logic             dur_run, dur_last;
    logic [CNT_W-1:0] dur_target;

    aclink_bclk_mon #(.ABSENT_CYCLES(ABSENT_CYCLES)) mon_i (
        .clk(clk), .rst_n(rst_n), .bitclk(bitclk),
        .bclk_edge(bclk_edge), .clk_present(clk_present)
    );

    aclink_dur_cnt #(.CNT_W(CNT_W)) dur_i (
        .clk(clk), .rst_n(rst_n), .run(dur_run),
        .target(dur_target), .last(dur_last)
    );

    aclink_rst_fsm #(.CNT_W(CNT_W), .CLK_MHZ(CLK_MHZ)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .cold_req(cold_req), .warm_req(warm_req),
        .cold_cycles(cold_cycles), .warm_cycles(warm_cycles),
        .irq_en(irq_en), .clr_flags(clr_flags),
        .clk_present(clk_present), .bclk_edge(bclk_edge),
        .dur_last(dur_last), .dur_run(dur_run), .dur_target(dur_target),
        .codec_rst_n(codec_rst_n), .sync_o(sync_o), .ctl_en(ctl_en),
        .busy(busy), .sof_flag(sof_flag), .err_flag(err_flag), .irq(irq)
    );
endmodule

// File: tb/aclink_rst_seq_tb_top.sv
// Bench: a behavioural reference model compared every cycle, plus
// directed checks of pulse widths, refusals and flag priorities.
module aclink_rst_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int CLK_MHZ    = 100;
    localparam int ABSENT     = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cold_req = 1'b0, warm_req = 1'b0, irq_en = 1'b0, clr_flags = 1'b0;
    logic [CNT_W-1:0] cold_cycles = '0, warm_cycles = '0;
    logic bitclk = 1'b0, bclk_run = 1'b0;
    logic codec_rst_n, sync_o, ctl_en, busy, sof_flag, err_flag, irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aclink_rst_seq #(.CNT_W(CNT_W), .CLK_MHZ(CLK_MHZ), .ABSENT_CYCLES(ABSENT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cold_req(cold_req), .warm_req(warm_req),
        .cold_cycles(cold_cycles), .warm_cycles(warm_cycles), .irq_en(irq_en),
        .clr_flags(clr_flags), .bitclk(bitclk), .codec_rst_n(codec_rst_n),
        .sync_o(sync_o), .ctl_en(ctl_en), .busy(busy), .sof_flag(sof_flag),
        .err_flag(err_flag), .irq(irq)
    );

    // Emulated codec bit clock: toggles every two system cycles when running.
    int bdiv = 0;
    always @(negedge clk) begin
        if (bclk_run) begin
            bdiv = bdiv + 1;
            if (bdiv >= 2) begin bdiv = 0; bitclk = ~bitclk; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: 0 idle, 1 ctl clear, 2 cold low, 3 warm high, 4 wait.
    int m_st, m_cnt, m_idle;
    int m_present, m_sof, m_err;
    int bq[$];
    always @(posedge clk) begin
        int tc, tw, e, sset, eset;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_idle = 0; m_present = 0; m_sof = 0; m_err = 0;
            bq = {0, 0, 0};
        end else begin
            tc = (cold_cycles == 0) ? 1 : int'(cold_cycles);
            tw = (warm_cycles == 0) ? CLK_MHZ : int'(warm_cycles);
            e = (bq[1] != bq[2]) ? 1 : 0;
            sset = 0; eset = 0;
            case (m_st)
                0: if (cold_req) m_st = 1;
                   else if (warm_req) begin
                       if (m_present != 0) eset = 1;
                       else begin m_st = 3; m_cnt = 0; end
                   end
                1: begin m_st = 2; m_cnt = 0; end
                2: if (m_cnt == tc - 1) begin m_st = 4; m_cnt = 0; end else m_cnt++;
                3: if (m_cnt == tw - 1) begin m_st = 4; m_cnt = 0; end else m_cnt++;
                default: if (e != 0) begin m_st = 0; sset = 1; end
            endcase
            if (sset != 0) m_sof = 1; else if (clr_flags) m_sof = 0;
            if (eset != 0) m_err = 1; else if (clr_flags) m_err = 0;
            if (e != 0) begin m_idle = 0; m_present = 1; end
            else if (m_idle < ABSENT - 1) m_idle++;
            else m_present = 0;
            bq = {int'(bitclk), bq[0], bq[1]};
        end
    end

    // Per-cycle comparison against the model, a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            chk("R2 codec_rst_n", int'(codec_rst_n), (m_st != 2) ? 1 : 0);
            chk("R2 ctl_en",      int'(ctl_en),      (m_st != 1) ? 1 : 0);
            chk("R3 sync_o",      int'(sync_o),      (m_st == 3) ? 1 : 0);
            chk("R6 busy",        int'(busy),        (m_st != 0) ? 1 : 0);
            chk("R8 sof_flag",    int'(sof_flag),    m_sof);
            chk("R5 err_flag",    int'(err_flag),    m_err);
            chk("R8 irq",         int'(irq),         (m_sof != 0 && irq_en) ? 1 : 0);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(input bit c, input bit w);
        @(negedge clk); cold_req = c; warm_req = w;
        @(negedge clk); cold_req = 1'b0; warm_req = 1'b0;
    endtask

    // Width of the next active pulse: sel 0 = codec reset low, 1 = sync high.
    task automatic pulse_width(input int sel, output int w);
        int guard = 0;
        w = 0;
        while (((sel == 0) ? !codec_rst_n : sync_o) == 1'b0 && guard < 400) begin
            @(negedge clk); guard++;
        end
        while (((sel == 0) ? !codec_rst_n : sync_o) == 1'b1 && w < 400) begin
            @(negedge clk); w++;
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 400) begin @(negedge clk); guard++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int w;
        cyc(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: state after reset
        chk("R1 codec_rst_n", int'(codec_rst_n), 1);
        chk("R1 sync_o", int'(sync_o), 0);
        chk("R1 ctl_en", int'(ctl_en), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 flags", int'({sof_flag, err_flag, irq}), 0);

        // Cold reset of 5 cycles with the bit clock stopped.
        cold_cycles = 16'd5;
        pulse_req(1'b1, 1'b0);
        chk("R2 ctl_en clear", int'(ctl_en), 0);
        pulse_width(0, w);
        chk("R2 cold low width", w, 5);
        chk("R6 busy while waiting", int'(busy), 1);
        bclk_run = 1'b1;
        wait_idle();
        chk("R8 sof after cold", int'(sof_flag), 1);
        chk("R8 irq masked", int'(irq), 0);
        irq_en = 1'b1; @(negedge clk);
        chk("R8 irq enabled", int'(irq), 1);
        @(negedge clk); clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
        chk("R9 sof cleared", int'(sof_flag), 0);

        // Warm request while the bit clock runs: refused.
        pulse_req(1'b0, 1'b1);
        cyc(2);
        chk("R5 err set", int'(err_flag), 1);
        chk("R5 not busy", int'(busy), 0);
        chk("R5 no sync", int'(sync_o), 0);
        @(negedge clk); clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
        chk("R9 err cleared", int'(err_flag), 0);

        // Clock just stopped: still judged present for the window.
        bclk_run = 1'b0;
        cyc(10);
        pulse_req(1'b0, 1'b1);
        cyc(1);
        chk("R7 still present", int'(err_flag), 1);
        @(negedge clk); clr_flags = 1'b1; @(negedge clk); clr_flags = 1'b0;
        cyc(ABSENT + 5);

        // Warm reset of 7 cycles; a cold request during it is ignored.
        warm_cycles = 16'd7;
        pulse_req(1'b0, 1'b1);
        chk("R7 absent accepted", int'(busy), 1);
        cold_req = 1'b1;
        pulse_width(1, w);
        cold_req = 1'b0;
        chk("R3 warm high width", w, 7);
        chk("R6 ignored cold", int'(codec_rst_n && ctl_en), 1);
        pulse_req(1'b1, 1'b1);
        chk("R6 ignored while busy", int'(codec_rst_n && ctl_en && !sync_o), 1);
        bclk_run = 1'b1;
        wait_idle();
        chk("R8 sof after warm", int'(sof_flag), 1);

        // Default warm width and set-over-clear collision.
        bclk_run = 1'b0;
        cyc(ABSENT + 10);
        warm_cycles = '0;
        pulse_req(1'b0, 1'b1);
        pulse_width(1, w);
        chk("R3 default width", w, CLK_MHZ);
        @(negedge clk); clr_flags = 1'b1;
        bclk_run = 1'b1;
        wait_idle();
        chk("R9 set wins", int'(sof_flag), 1);
        @(negedge clk);
        chk("R9 clear after", int'(sof_flag), 0);
        clr_flags = 1'b0;

        // Cold with zero length, and cold+warm together.
        bclk_run = 1'b0;
        cyc(ABSENT + 10);
        cold_cycles = '0;
        pulse_req(1'b1, 1'b1);
        chk("R4 cold wins", int'(ctl_en), 0);
        chk("R4 no sync", int'(sync_o), 0);
        pulse_width(0, w);
        chk("R2 zero means one", w, 1);
        bclk_run = 1'b1;
        wait_idle();
        chk("R6 busy released", int'(busy), 0);
        cyc(5);
        finish_run();
    end
endmodule